// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This engine sits below a byte or transaction sequencer and performs single bus-level operations on an open-drain I2C bus. The supported operations are a start condition, a stop condition, sending one data bit, and receiving one data bit. The engine never drives a line high. It has two drive-low enables, one for SDA and one for SCL, and reads both wires back through two-flop synchronisers. Every decision is based on the levels the wires actually show, not on the levels the engine requested.

Two run-time counts shape the bus timing. The settle count is the number of clock cycles inserted between successive line changes; about 5 us worth suits standard mode. The stretch limit is how many cycles the engine waits for a released SCL to read high before it gives up with a timeout.

Each operation ends with a one-cycle completion pulse and a 2-bit status. For receives, the sampled bit is also returned. Hard faults end the operation immediately: timeout, arbitration loss during start, and a transmitted 1 that the wire refuses to show. A low SDA after a stop is only a soft warning beside an ok status. After any fault the engine goes idle and leaves SCL where it was, so a higher-level controller can decide on recovery.

Top module: `i2c_bit_engine`

## Requirements
- R1: Out of reset both drive enables are 0 (lines released), busy is 0 and done is 0.
- R2: An operation is accepted only when busy is 0 and op_valid is 1. op_code 0 is start, 1 is stop, 2 is send bit (op_bit), 3 is receive bit. An op_valid seen while busy has no effect on the bus or on the results.
- R3: done is high for exactly one cycle per accepted operation. In the same cycle status is valid: 0 ok, 1 stretch timeout, 2 arbitration lost, 3 SDA wedged. status, rx_bit and stop_warn hold their values until the next accepted operation.
- R4: After the engine changes one line, it waits at least settle_cycles clock cycles before changing the next line.
- R5: After releasing SCL, the engine waits for the synchronised SCL to read high. If it does not read high within stretch_limit cycles, the operation ends with status 1.
- R6: Start sequence: release SDA and settle; release SCL, await high, settle; drive SDA low and settle; drive SCL low. On success both enables end at 1.
- R7: During start, if SDA reads low after SCL has been high for the settle time, the operation ends with status 2 and SDA is not driven.
- R8: Stop sequence: drive SDA low and settle; release SCL, await high, settle; release SDA and settle. Status is always 0 and both enables end at 0. stop_warn is 1 when SDA then still reads low, and 0 otherwise.
- R9: Send bit: put op_bit on SDA and settle; release SCL, await high, settle; drive SCL low. When op_bit is 1 and SDA reads low, the operation ends with status 3. This check is made both before SCL is released and after the high period.
- R10: Receive bit: SDA is released, and rx_bit is the SDA level sampled as soon as SCL is seen high. The operation then ends with SCL driven low and SDA released.
- R11: After a fault the engine is idle again. It leaves SCL as it was: driven low for a wedge found before the clock pulse, released for a timeout or an arbitration loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation request, taken when idle |
| op_code | input | 2 | 0 start, 1 stop, 2 send bit, 3 receive bit |
| op_bit | input | 1 | Data bit for a send |
| settle_cycles | input | SETTLE_W | Cycles between line changes |
| stretch_limit | input | STRETCH_W | Maximum cycles to wait for SCL high |
| sda_in | input | 1 | SDA wire level |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion code |
| rx_bit | output | 1 | Received bit |
| stop_warn | output | 1 | SDA low after stop |

## Verification
Most internal errors show up at the two drive enables first. A wrong phase or a miscounted settle changes the order or spacing of sda_oe and scl_oe edges within one settle window of the mistake. A wrong decision on the sampled line shows at the done pulse as a wrong status, a wrong rx_bit or a wrong final level of SCL. The stimulus therefore holds the bus wires from a slave model and checks the status, the returned bit and both enables at every completion. It also measures edge spacing and stretch latency in clock cycles.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

    typedef enum logic [1:0] {
        OP_START = 2'd0,
        OP_STOP  = 2'd1,
        OP_SEND  = 2'd2,
        OP_RECV  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_TIMEOUT = 2'd1,
        RES_ARB     = 2'd2,
        RES_WEDGED  = 2'd3
    } res_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STRETCH,
        PH_HIGH,
        PH_START_LOW,
        PH_STOP_REL
    } phase_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] synced
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         hit
);
    logic [W-1:0] cnt;

    assign hit = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (clr)  cnt <= '0;
        else if (!hit) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int SETTLE_W  = 16,
    parameter int STRETCH_W = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [1:0]           op_code,
    input  logic                 op_bit,
    input  logic [SETTLE_W-1:0]  settle_cycles,
    input  logic [STRETCH_W-1:0] stretch_limit,
    input  logic                 sda_in,
    input  logic                 scl_in,
    output logic                 sda_oe,
    output logic                 scl_oe,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status,
    output logic                 rx_bit,
    output logic                 stop_warn
);
    localparam int TW = (SETTLE_W > STRETCH_W) ? SETTLE_W : STRETCH_W;

    phase_e phase_q, phase_d;
    op_e    op_q, op_d;
    res_e   res_q, res_d;
    logic   bit_q, bit_d;
    logic   sda_oe_q, sda_oe_d, scl_oe_q, scl_oe_d;
    logic   done_q, done_d, rx_q, rx_d, warn_q, warn_d;

    logic [1:0]    lines_s;
    logic          sda_s, scl_s;
    logic          tmr_clr, tmr_hit;
    logic [TW-1:0] tmr_limit;

    i2c_line_sync #(.LINES(2), .STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    ({scl_in, sda_in}),
        .synced (lines_s)
    );
    assign sda_s = lines_s[0];
    assign scl_s = lines_s[1];

    i2c_phase_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .limit (tmr_limit),
        .hit   (tmr_hit)
    );

    assign tmr_limit = (phase_q == PH_STRETCH) ? TW'(stretch_limit) : TW'(settle_cycles);
    assign tmr_clr   = (phase_q == PH_IDLE) || (phase_d != phase_q);

    // next-state and next-output logic
    always_comb begin
        phase_d  = phase_q;
        op_d     = op_q;
        bit_d    = bit_q;
        res_d    = res_q;
        sda_oe_d = sda_oe_q;
        scl_oe_d = scl_oe_q;
        rx_d     = rx_q;
        warn_d   = warn_q;
        done_d   = 1'b0;
        unique case (phase_q)
            PH_IDLE: begin
                if (op_valid) begin
                    op_d    = op_e'(op_code);
                    bit_d   = op_bit;
                    warn_d  = 1'b0;
                    phase_d = PH_SETUP;
                    unique case (op_e'(op_code))
                        OP_STOP: sda_oe_d = 1'b1;
                        OP_SEND: sda_oe_d = ~op_bit;
                        default: sda_oe_d = 1'b0;
                    endcase
                end
            end
            PH_SETUP: begin
                if (tmr_hit) begin
                    if (op_q == OP_SEND && bit_q && !sda_s) begin
                        res_d   = RES_WEDGED;
                        done_d  = 1'b1;
                        phase_d = PH_IDLE;
                    end else begin
                        scl_oe_d = 1'b0;
                        phase_d  = PH_STRETCH;
                    end
                end
            end
            PH_STRETCH: begin
                if (scl_s) begin
                    if (op_q == OP_RECV) rx_d = sda_s;
                    phase_d = PH_HIGH;
                end else if (tmr_hit) begin
                    res_d   = RES_TIMEOUT;
                    done_d  = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            PH_HIGH: begin
                if (tmr_hit) begin
                    unique case (op_q)
                        OP_START: begin
                            if (!sda_s) begin
                                res_d   = RES_ARB;
                                done_d  = 1'b1;
                                phase_d = PH_IDLE;
                            end else begin
                                sda_oe_d = 1'b1;
                                phase_d  = PH_START_LOW;
                            end
                        end
                        OP_STOP: begin
                            sda_oe_d = 1'b0;
                            phase_d  = PH_STOP_REL;
                        end
                        OP_SEND: begin
                            if (bit_q && !sda_s) begin
                                res_d = RES_WEDGED;
                            end else begin
                                res_d    = RES_OK;
                                scl_oe_d = 1'b1;
                            end
                            done_d  = 1'b1;
                            phase_d = PH_IDLE;
                        end
                        default: begin
                            res_d    = RES_OK;
                            scl_oe_d = 1'b1;
                            done_d   = 1'b1;
                            phase_d  = PH_IDLE;
                        end
                    endcase
                end
            end
            PH_START_LOW: begin
                if (tmr_hit) begin
                    scl_oe_d = 1'b1;
                    res_d    = RES_OK;
                    done_d   = 1'b1;
                    phase_d  = PH_IDLE;
                end
            end
            PH_STOP_REL: begin
                if (tmr_hit) begin
                    warn_d  = ~sda_s;
                    res_d   = RES_OK;
                    done_d  = 1'b1;
                    phase_d = PH_IDLE;
                end
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            op_q    <= OP_START;
            bit_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            op_q    <= op_d;
            bit_q   <= bit_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe_q <= 1'b0;
            scl_oe_q <= 1'b0;
            done_q   <= 1'b0;
            res_q    <= RES_OK;
            rx_q     <= 1'b0;
            warn_q   <= 1'b0;
        end else begin
            sda_oe_q <= sda_oe_d;
            scl_oe_q <= scl_oe_d;
            done_q   <= done_d;
            res_q    <= res_d;
            rx_q     <= rx_d;
            warn_q   <= warn_d;
        end
    end

    assign sda_oe    = sda_oe_q;
    assign scl_oe    = scl_oe_q;
    assign busy      = (phase_q != PH_IDLE);
    assign done      = done_q;
    assign status    = res_q;
    assign rx_bit    = rx_q;
    assign stop_warn = warn_q;

    a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !op_valid) |=> ($stable(sda_oe) && $stable(scl_oe) && !busy));
    a_r2_busy_holds_op: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(op_q));
    a_r5_scl_free_in_stretch: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_STRETCH) |-> !scl_oe);
    a_r8_warn_is_soft: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stop_warn) |-> (status == RES_OK));
    a_r6_start_leaves_low: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == RES_OK && op_q == OP_START) |-> (sda_oe && scl_oe));
    a_r11_timeout_releases: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == RES_TIMEOUT) |-> !scl_oe);

endmodule

// File: tb/i2c_bit_engine_tb.sv
`timescale 1ns/1ps
module i2c_bit_engine_tb;
    localparam int SETTLE  = 8;
    localparam int STRETCH = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic        op_bit = 1'b0;
    logic        slv_sda_low = 1'b0;
    logic        slv_scl_low = 1'b0;
    logic        sda_in, scl_in, sda_oe, scl_oe, busy, done, rx_bit, stop_warn;
    logic [1:0]  status;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 0;

    always #2.5 clk = ~clk;

    assign sda_in = ~(sda_oe | slv_sda_low);
    assign scl_in = ~(scl_oe | slv_scl_low);

    i2c_bit_engine u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .op_bit(op_bit), .settle_cycles(16'(SETTLE)), .stretch_limit(24'(STRETCH)),
        .sda_in(sda_in), .scl_in(scl_in), .sda_oe(sda_oe), .scl_oe(scl_oe),
        .busy(busy), .done(done), .status(status), .rx_bit(rx_bit), .stop_warn(stop_warn)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] code, input logic b, output int lat);
        @(negedge clk);
        op_code  = code;
        op_bit   = b;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        lat = 1;
        while (!done && lat < 20000) begin
            @(negedge clk);
            lat++;
        end
        chk(done == 1'b1, "R3 done seen", int'(done), 1);
    endtask

    // {code[1:0], bit, slave_hold_sda, status[1:0], rx, warn}
    localparam int NV = 11;
    localparam logic [7:0] VEC [NV] = '{
        {2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R6 start
        {2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},  // R9 send 1
        {2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R9 send 0
        {2'd3, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},  // R10 receive 0
        {2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},  // R10 receive 1
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R8 stop clean
        {2'd0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R6 start
        {2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0},  // R9 wedged
        {2'd1, 1'b0, 1'b1, 2'd0, 1'b0, 1'b1},  // R8 stop warn
        {2'd0, 1'b0, 1'b1, 2'd2, 1'b0, 1'b0},  // R7 arbitration
        {2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0}   // R8 stop clean
    };

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sda_oe == 0 && scl_oe == 0, "R1 lines released", int'({sda_oe, scl_oe}), 0);
        chk(busy == 0 && done == 0, "R1 idle", int'({busy, done}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(sda_oe == 0 && scl_oe == 0 && busy == 0, "R1 after release", int'({sda_oe, scl_oe, busy}), 0);

        for (int i = 0; i < NV; i++) begin
            logic [7:0] v;
            v = VEC[i];
            slv_sda_low = v[4];
            run_op(v[7:6], v[5], lat);
            chk(status == v[3:2], $sformatf("R3 status vec %0d", i), int'(status), int'(v[3:2]));
            if (v[7:6] == 2'd3)
                chk(rx_bit == v[1], $sformatf("R10 rx vec %0d", i), int'(rx_bit), int'(v[1]));
            if (v[7:6] == 2'd1) begin
                chk(stop_warn == v[0], $sformatf("R8 warn vec %0d", i), int'(stop_warn), int'(v[0]));
                chk(sda_oe == 0 && scl_oe == 0, $sformatf("R8 released vec %0d", i), int'({sda_oe, scl_oe}), 0);
            end
            if (v[7:6] == 2'd0 && v[3:2] == 2'd0)
                chk(sda_oe == 1 && scl_oe == 1, $sformatf("R6 ends low vec %0d", i), int'({sda_oe, scl_oe}), 3);
            if (v[7:6] == 2'd3)
                chk(sda_oe == 0 && scl_oe == 1, $sformatf("R10 ends vec %0d", i), int'({sda_oe, scl_oe}), 1);
            if (i == 7) chk(scl_oe == 1 && busy == 0, "R11 wedge keeps SCL low", int'(scl_oe), 1);
            if (i == 9) chk(scl_oe == 0 && sda_oe == 0 && busy == 0, "R11 R7 arb keeps SCL free", int'({sda_oe, scl_oe}), 0);
            slv_sda_low = 1'b0;
        end

        // R4 settle spacing between SDA fall and SCL fall during start
        begin
            int gap;
            @(negedge clk);
            op_code = 2'd0; op_valid = 1'b1;
            @(negedge clk);
            op_valid = 1'b0;
            while (!sda_oe) @(negedge clk);
            gap = 0;
            while (!scl_oe) begin @(negedge clk); gap++; end
            chk(gap >= SETTLE, "R4 settle gap", gap, SETTLE);
            while (busy) @(negedge clk);
        end

        // R5 short stretch tolerated
        fork
            run_op(2'd2, 1'b0, lat);
            begin
                slv_scl_low = 1'b1;
                repeat (40) @(negedge clk);
                slv_scl_low = 1'b0;
            end
        join
        chk(status == 2'd0, "R5 short stretch ok", int'(status), 0);
        chk(lat > 40, "R5 waited for SCL", lat, 41);

        // R2 op while busy is ignored (receive would release SDA)
        fork
            run_op(2'd2, 1'b0, lat);
            begin
                repeat (4) @(negedge clk);
                op_code = 2'd3; op_valid = 1'b1;
                @(negedge clk);
                op_valid = 1'b0;
            end
        join
        chk(sda_oe == 1 && scl_oe == 1, "R2 busy op ignored", int'({sda_oe, scl_oe}), 3);
        begin
            int extra;
            extra = 0;
            repeat (60) begin @(negedge clk); if (done || busy) extra++; end
            chk(extra == 0, "R2 no second operation", extra, 0);
        end

        // R5 R11 stretch timeout
        slv_scl_low = 1'b1;
        run_op(2'd2, 1'b1, lat);
        chk(status == 2'd1, "R5 timeout status", int'(status), 1);
        chk(lat >= STRETCH, "R5 timeout latency", lat, STRETCH);
        chk(scl_oe == 0 && busy == 0, "R11 timeout leaves SCL released", int'(scl_oe), 0);
        slv_scl_low = 1'b0;
        run_op(2'd1, 1'b0, lat);
        chk(status == 2'd0 && stop_warn == 0, "R8 recovery stop", int'(status), 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule